// File: doc/BRIEF.md
# Run-Length Infrared Transmitter with Carrier Modulation

This block turns a stream of run-length samples into an infrared drive waveform. The host places samples into a small ring of output slots, two by default. The engine takes them in strict rotation, always starting at slot 0. Each sample is one byte. It says whether the run is a pulse or a gap and how many sample ticks the run lasts. During a pulse the output carries a square carrier. The carrier period and its high time are both programmed in half-microsecond units. During a gap the output rests at its idle level.

The host fills a slot while the engine plays the other one. It watches the per-slot empty flags to know when a slot can be reused. A sample with a zero length ends the transmission. So does a slot that is still empty when the engine needs it. The engine then parks and can raise a done interrupt.

Several options shape the output:
- The carrier can be switched off, so that pulses become steady on-levels.
- The carrier waveform can be inverted inside pulses.
- The whole output can be inverted.
- Dropping the enable stops the engine at once.

Top module: `ir_rl_tx`

## Requirements
- R1: After reset, `ir_out` is 0, `done_irq` is 0, `busy` is 0 and every bit of `slot_empty` is 1.
- R2: A sample byte uses bit 7 as the pulse flag (1 = pulse, 0 = gap) and bits 6:0 as the run length in sample ticks. A run of length L lasts exactly L*SAMPLE_DIV clock cycles. Slots are taken in rotation from slot 0 after each start. `busy` is 1 while a run plays.
- R3: Throughout a gap, and whenever no run plays, `ir_out` equals `out_inv`.
- R4: During a pulse that follows a gap or idle, with the carrier enabled, the carrier phase restarts at 0 and advances every HALF_US_DIV cycles, modulo the period. The carrier is high while the phase is below the high time. `ir_out` shows the engine state one cycle later.
- R5: A period field (bits 6:0 of `carr_prd`) below 2 acts as 2. A high time at or above the effective period acts as period minus one.
- R6: Bit 7 of `carr_prd` inverts the carrier waveform within pulses.
- R7: With `carr_en` low, a pulse drives a steady active level, the inverse of `out_inv`.
- R8: `out_inv` inverts `ir_out` in every state, including idle and gaps.
- R9: Taking a zero-length sample ends the transmission. The slot is freed, `busy` falls and the engine stays done until `tx_en` falls.
- R10: If the next slot is empty when a sample is needed, the output goes idle and the engine is done. This includes the very first sample after a start.
- R11: `done_irq` is 1 from the cycle the engine becomes done until `tx_en` falls, and only while `done_irq_en` is set.
- R12: Dropping `tx_en` clears `busy` and `done_irq` on the next cycle, and the output reaches idle level one cycle later.
- R13: A slot's `slot_empty` bit goes to 0 the cycle after it is written, and to 1 the cycle after the engine takes it. A write wins over a take in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_en | input | 1 | Starts the engine on a rising level; low stops it |
| carr_en | input | 1 | 1 = pulses carry the carrier, 0 = steady on-level |
| out_inv | input | 1 | Inverts the whole output |
| done_irq_en | input | 1 | Enables the done interrupt |
| carr_prd | input | 8 | Bit 7 carrier polarity, bits 6:0 period in 500 ns units |
| carr_high | input | 7 | Carrier high time in 500 ns units |
| buf_wr | input | 1 | Write strobe for a sample slot |
| buf_wr_sel | input | SEL_W | Slot index to write |
| buf_wr_data | input | 8 | Sample byte: bit 7 pulse flag, bits 6:0 length |
| slot_empty | output | NSLOT | One bit per slot, 1 when the slot may be refilled |
| busy | output | 1 | A run is playing |
| done_irq | output | 1 | Done interrupt, held until tx_en falls |
| ir_out | output | 1 | Registered infrared drive output |

## Verification
On every cycle, the checker confirms the following:
- the output sits at idle level outside pulses, and at the active level for carrier-less pulses;
- a low enable clears `busy` and the interrupt;
- the interrupt never appears without its enable;
- a written slot reads as full;
- `busy` and `done_irq` are never both high.

The exact carrier shape needs the bench's sweeps, where every output cycle is compared against a value computed from the programmed period, high time, polarity and inversion. These sweeps cover clamping and run durations. The end conditions (terminator versus starved slot) and the refill timing also come only from the bench's streams.

// File: rtl/ir_tx_pkg.sv
package ir_tx_pkg;

  localparam int SMP_W = 8;
  localparam int LEN_W = 7;
  localparam int CAR_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tx_state_e;

  // Effective carrier period: never below two half-microsecond units.
  function automatic logic [CAR_W-1:0] eff_period(input logic [CAR_W-1:0] p);
    return (p < CAR_W'(2)) ? CAR_W'(2) : p;
  endfunction

  // Effective high time: always leaves at least one low unit per period.
  function automatic logic [CAR_W-1:0] eff_high(input logic [CAR_W-1:0] h,
                                                input logic [CAR_W-1:0] pe);
    return (h >= pe) ? (pe - CAR_W'(1)) : h;
  endfunction

endpackage

// File: rtl/ir_tx_divider.sv
module ir_tx_divider #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + CW'(1);
    end
  end

  assign tick = run && (cnt_q == CW'(DIV - 1));
endmodule

// File: rtl/ir_tx_slots.sv
module ir_tx_slots #(
  parameter int NSLOT = 2,
  parameter int DW    = 8,
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic [DW-1:0]    wr_data,
  input  logic [SEL_W-1:0] rd_sel,
  input  logic             take,
  output logic [DW-1:0]    rd_data,
  output logic             rd_full,
  output logic [NSLOT-1:0] empty
);
  logic [DW-1:0]    mem [NSLOT];
  logic [NSLOT-1:0] full_q;

  always_ff @(posedge clk) begin
    if (wr) mem[wr_sel] <= wr_data;
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[i] <= 1'b0;
      end else if (wr && (wr_sel == SEL_W'(i))) begin
        full_q[i] <= 1'b1;
      end else if (take && (rd_sel == SEL_W'(i))) begin
        full_q[i] <= 1'b0;
      end
    end
  end

  assign rd_data = mem[rd_sel];
  assign rd_full = full_q[rd_sel];
  assign empty   = ~full_q;
endmodule

// File: rtl/ir_tx_seq.sv
module ir_tx_seq
  import ir_tx_pkg::*;
#(
  parameter int NSLOT = 2,
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             tick,
  input  logic [SMP_W-1:0] slot_data,
  input  logic             slot_full,
  output logic [SEL_W-1:0] rd_sel,
  output logic             take,
  output logic             busy,
  output logic             pulse_act,
  output logic             done_next
);
  tx_state_e        st_q, st_d;
  logic [SEL_W-1:0] rd_q, rd_d;
  logic [LEN_W-1:0] rem_q;
  logic             pul_q;
  logic             need, load;
  logic [LEN_W-1:0] smp_len;

  assign smp_len = slot_data[LEN_W-1:0];

  always_comb begin
    need = (st_q == ST_IDLE) ||
           ((st_q == ST_RUN) && tick && (rem_q == LEN_W'(1)));
    st_d = st_q;
    take = 1'b0;
    load = 1'b0;
    if (!tx_en) begin
      st_d = ST_IDLE;
    end else if (need) begin
      take = slot_full;
      if (slot_full && (smp_len != '0)) begin
        st_d = ST_RUN;
        load = 1'b1;
      end else begin
        st_d = ST_DONE;
      end
    end
  end

  always_comb begin
    if (st_d == ST_IDLE) begin
      rd_d = '0;
    end else if (take) begin
      rd_d = (rd_q == SEL_W'(NSLOT - 1)) ? '0 : rd_q + SEL_W'(1);
    end else begin
      rd_d = rd_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_IDLE;
      rd_q  <= '0;
      rem_q <= '0;
      pul_q <= 1'b0;
    end else begin
      st_q <= st_d;
      rd_q <= rd_d;
      if (load) begin
        rem_q <= smp_len;
        pul_q <= slot_data[SMP_W-1];
      end else if ((st_q == ST_RUN) && tick) begin
        rem_q <= rem_q - LEN_W'(1);
      end
    end
  end

  assign rd_sel    = rd_q;
  assign busy      = (st_q == ST_RUN);
  assign pulse_act = (st_q == ST_RUN) && pul_q;
  assign done_next = (st_d == ST_DONE);
endmodule

// File: rtl/ir_tx_carrier.sv
module ir_tx_carrier
  import ir_tx_pkg::*;
#(
  parameter int HALF_US_DIV = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic [CAR_W-1:0] prd,
  input  logic [CAR_W-1:0] high,
  input  logic             pol,
  output logic             wave
);
  logic             hu_tick;
  logic [CAR_W-1:0] phase_q;
  logic [CAR_W-1:0] pe, he;

  ir_tx_divider #(.DIV(HALF_US_DIV)) u_hu_div (
    .clk  (clk),
    .rst  (rst),
    .run  (active),
    .tick (hu_tick)
  );

  always_comb begin
    pe = eff_period(prd);
    he = eff_high(high, pe);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      phase_q <= '0;
    end else if (hu_tick) begin
      phase_q <= (phase_q >= pe - CAR_W'(1)) ? '0 : phase_q + CAR_W'(1);
    end
  end

  assign wave = (phase_q < he) ^ pol;
endmodule

// File: rtl/ir_rl_tx.sv
module ir_rl_tx
  import ir_tx_pkg::*;
#(
  parameter int HALF_US_DIV = 50,
  parameter int SAMPLE_DIV  = 5000,
  parameter int NSLOT       = 2,
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tx_en,
  input  logic             carr_en,
  input  logic             out_inv,
  input  logic             done_irq_en,
  input  logic [7:0]       carr_prd,
  input  logic [6:0]       carr_high,
  input  logic             buf_wr,
  input  logic [SEL_W-1:0] buf_wr_sel,
  input  logic [7:0]       buf_wr_data,
  output logic [NSLOT-1:0] slot_empty,
  output logic             busy,
  output logic             done_irq,
  output logic             ir_out
);
  logic [SEL_W-1:0] rd_sel;
  logic [SMP_W-1:0] slot_data;
  logic             slot_full;
  logic             take;
  logic             smp_tick;
  logic             pulse_act;
  logic             done_next;
  logic             wave;
  logic             ir_q, irq_q;

  ir_tx_slots #(.NSLOT(NSLOT), .DW(SMP_W)) u_slots (
    .clk     (clk),
    .rst     (rst),
    .wr      (buf_wr),
    .wr_sel  (buf_wr_sel),
    .wr_data (buf_wr_data),
    .rd_sel  (rd_sel),
    .take    (take),
    .rd_data (slot_data),
    .rd_full (slot_full),
    .empty   (slot_empty)
  );

  ir_tx_divider #(.DIV(SAMPLE_DIV)) u_smp_div (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .tick (smp_tick)
  );

  ir_tx_seq #(.NSLOT(NSLOT)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .tx_en     (tx_en),
    .tick      (smp_tick),
    .slot_data (slot_data),
    .slot_full (slot_full),
    .rd_sel    (rd_sel),
    .take      (take),
    .busy      (busy),
    .pulse_act (pulse_act),
    .done_next (done_next)
  );

  ir_tx_carrier #(.HALF_US_DIV(HALF_US_DIV)) u_carr (
    .clk    (clk),
    .rst    (rst),
    .active (pulse_act),
    .prd    (carr_prd[CAR_W-1:0]),
    .high   (carr_high),
    .pol    (carr_prd[7]),
    .wave   (wave)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      ir_q  <= (pulse_act ? (carr_en ? wave : 1'b1) : 1'b0) ^ out_inv;
      irq_q <= done_next && done_irq_en;
    end
  end

  assign ir_out   = ir_q;
  assign done_irq = irq_q;
endmodule

// File: rtl/ir_rl_tx_chk.sv
module ir_rl_tx_chk #(
  parameter int NSLOT = 2,
  localparam int SEL_W = (NSLOT > 1) ? $clog2(NSLOT) : 1
) (
  input logic             clk,
  input logic             rst,
  input logic             tx_en,
  input logic             carr_en,
  input logic             out_inv,
  input logic             done_irq_en,
  input logic             buf_wr,
  input logic [SEL_W-1:0] buf_wr_sel,
  input logic [NSLOT-1:0] slot_empty,
  input logic             busy,
  input logic             done_irq,
  input logic             ir_out,
  input logic             pulse_act
);
  assert_idle_level_R3: assert property (@(posedge clk) disable iff (rst)
    !pulse_act |=> (ir_out == $past(out_inv)));

  assert_plain_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    (pulse_act && !carr_en) |=> (ir_out != $past(out_inv)));

  assert_stop_clears_R12: assert property (@(posedge clk) disable iff (rst)
    !tx_en |=> (!busy && !done_irq));

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (rst)
    done_irq |-> $past(done_irq_en));

  assert_write_fills_R13: assert property (@(posedge clk) disable iff (rst)
    buf_wr |=> !slot_empty[$past(buf_wr_sel)]);

  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    !(busy && done_irq));
endmodule

bind ir_rl_tx ir_rl_tx_chk #(.NSLOT(NSLOT)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .tx_en       (tx_en),
  .carr_en     (carr_en),
  .out_inv     (out_inv),
  .done_irq_en (done_irq_en),
  .buf_wr      (buf_wr),
  .buf_wr_sel  (buf_wr_sel),
  .slot_empty  (slot_empty),
  .busy        (busy),
  .done_irq    (done_irq),
  .ir_out      (ir_out),
  .pulse_act   (pulse_act)
);

// File: tb/ir_rl_tx_bench.sv
`timescale 1ns/1ps
module ir_rl_tx_bench;
  localparam int HD = 2;
  localparam int SD = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_en = 1'b0, carr_en = 1'b0, out_inv = 1'b0, done_irq_en = 1'b0;
  logic [7:0] carr_prd = 8'd4;
  logic [6:0] carr_high = 7'd2;
  logic       buf_wr = 1'b0;
  logic [0:0] buf_wr_sel = 1'b0;
  logic [7:0] buf_wr_data = 8'd0;
  logic [1:0] slot_empty;
  logic       busy, done_irq, ir_out;

  int n_chk = 0;
  int n_fail = 0;

  // stream description for the model
  int smp_len [16];
  bit smp_pul [16];
  int nsmp;

  always #4 clk = ~clk;

  ir_rl_tx #(.HALF_US_DIV(HD), .SAMPLE_DIV(SD), .NSLOT(2)) u_ir_rl_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .carr_en(carr_en), .out_inv(out_inv),
    .done_irq_en(done_irq_en), .carr_prd(carr_prd), .carr_high(carr_high),
    .buf_wr(buf_wr), .buf_wr_sel(buf_wr_sel), .buf_wr_data(buf_wr_data),
    .slot_empty(slot_empty), .busy(busy), .done_irq(done_irq), .ir_out(ir_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int pe_f();
    int p = int'(carr_prd[6:0]);
    return (p < 2) ? 2 : p;
  endfunction

  function automatic int he_f();
    int h = int'(carr_high);
    return (h >= pe_f()) ? pe_f() - 1 : h;
  endfunction

  // expected ir_out driven by engine state after edge k (k = 0 is start edge)
  function automatic int exp_out(input int k);
    int st = 0;
    int inv = int'(out_inv);
    if (k < 0) return inv;
    for (int j = 0; j < nsmp; j++) begin
      int d = smp_len[j] * SD;
      if (k < st + d) begin
        int o, ph, w;
        if (!smp_pul[j]) return inv;
        o  = k - st;
        ph = (o / HD) % pe_f();
        w  = carr_en ? (((ph < he_f()) ? 1 : 0) ^ int'(carr_prd[7])) : 1;
        return w ^ inv;
      end
      st += d;
    end
    return inv;
  endfunction

  function automatic bit in_pulse(input int k);
    int st = 0;
    for (int j = 0; j < nsmp; j++) begin
      if (k >= st && k < st + smp_len[j] * SD) return smp_pul[j];
      st += smp_len[j] * SD;
    end
    return 1'b0;
  endfunction

  function automatic string out_tag(input int k);
    int p = int'(carr_prd[6:0]);
    if (k < 0 || !in_pulse(k)) return out_inv ? "R8" : "R3";
    if (!carr_en) return "R7";
    if (p < 2 || int'(carr_high) >= pe_f()) return "R5";
    if (carr_prd[7]) return "R6";
    if (out_inv) return "R8";
    return "R4";
  endfunction

  task automatic run_stream(input bit term);
    int total = 0;
    int nitm;
    logic [7:0] itm [17];
    for (int i = 0; i < nsmp; i++) begin
      total += smp_len[i] * SD;
      itm[i] = {smp_pul[i], 7'(smp_len[i])};
    end
    nitm = nsmp;
    if (term) begin
      itm[nsmp] = 8'h00;
      nitm++;
    end
    for (int i = 0; i < 2 && i < nitm; i++) begin
      @(negedge clk);
      buf_wr = 1'b1; buf_wr_sel = 1'(i); buf_wr_data = itm[i];
    end
    @(negedge clk);
    buf_wr = 1'b0;
    // R13: written slots report full
    chk("R13", int'(slot_empty), (nitm >= 2) ? 0 : ((nitm == 1) ? 2 : 3));
    tx_en = 1'b1;
    fork
      begin
        for (int i = 2; i < nitm; i++) begin
          do @(negedge clk); while (!slot_empty[i % 2]);
          buf_wr = 1'b1; buf_wr_sel = 1'(i % 2); buf_wr_data = itm[i];
          @(negedge clk);
          buf_wr = 1'b0;
        end
      end
      begin
        for (int n = 0; n <= total + 3; n++) begin
          @(negedge clk);
          if (n == 0 && nitm > 0) chk("R13", int'(slot_empty[0]), 1);
          chk(out_tag(n - 1), int'(ir_out), exp_out(n - 1));
          chk("R2", int'(busy), (total > 0 && n < total) ? 1 : 0);
          chk(!done_irq_en ? "R11" : (term ? "R9" : "R10"), int'(done_irq),
              (done_irq_en && n >= total) ? 1 : 0);
        end
      end
    join
    tx_en = 1'b0;
    @(negedge clk);
    chk("R11", int'(done_irq), 0);
    @(negedge clk);
    chk("R3", int'(ir_out), int'(out_inv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1", int'(ir_out), 0);
    chk("R1", int'(done_irq), 0);
    chk("R1", int'(busy), 0);
    chk("R1", int'(slot_empty), 3);

    // R4 R5 R6 R7 R8: sweep over carrier settings on pulse/gap/pulse + terminator
    begin
      int prds [6] = '{0, 1, 2, 3, 5, 127};
      int highs [6] = '{0, 1, 2, 4, 6, 127};
      nsmp = 3;
      smp_len[0] = 3; smp_pul[0] = 1'b1;
      smp_len[1] = 2; smp_pul[1] = 1'b0;
      smp_len[2] = 4; smp_pul[2] = 1'b1;
      for (int a = 0; a < 6; a++)
        for (int b = 0; b < 6; b++)
          for (int c = 0; c < 8; c++) begin
            carr_prd    = {c[2], 7'(prds[a])};
            carr_high   = 7'(highs[b]);
            carr_en     = c[0];
            out_inv     = c[1];
            done_irq_en = c[0] ^ c[1];
            run_stream(1'b1);
          end
    end

    // R2: rotation through both slots with repeated refills, long maximal pulse
    carr_prd = 8'd127; carr_high = 7'd63; carr_en = 1'b1; out_inv = 1'b0; done_irq_en = 1'b1;
    nsmp = 6;
    smp_len[0] = 5;   smp_pul[0] = 1'b0;
    smp_len[1] = 127; smp_pul[1] = 1'b1;
    smp_len[2] = 1;   smp_pul[2] = 1'b0;
    smp_len[3] = 2;   smp_pul[3] = 1'b1;
    smp_len[4] = 3;   smp_pul[4] = 1'b0;
    smp_len[5] = 1;   smp_pul[5] = 1'b1;
    run_stream(1'b1);
    carr_prd = 8'd3; carr_high = 7'd1;
    run_stream(1'b1);

    // R10: starvation after two samples, with and without the interrupt
    nsmp = 2;
    smp_len[0] = 2; smp_pul[0] = 1'b1;
    smp_len[1] = 3; smp_pul[1] = 1'b0;
    done_irq_en = 1'b1; run_stream(1'b0);
    done_irq_en = 1'b0; run_stream(1'b0);

    // R10: nothing loaded at start; R9: terminator as first sample
    nsmp = 0;
    done_irq_en = 1'b1; run_stream(1'b0);
    done_irq_en = 1'b1; out_inv = 1'b1; run_stream(1'b1);
    out_inv = 1'b0;

    // R12: abort in the middle of a steady pulse
    carr_en = 1'b0;
    @(negedge clk);
    buf_wr = 1'b1; buf_wr_sel = 1'b0; buf_wr_data = 8'h94;
    @(negedge clk);
    buf_wr = 1'b0; tx_en = 1'b1;
    repeat (10) @(negedge clk);
    chk("R7", int'(ir_out), 1);
    tx_en = 1'b0;
    @(negedge clk);
    chk("R12", int'(busy), 0);
    @(negedge clk);
    chk("R12", int'(ir_out), 0);
    chk("R13", int'(slot_empty), 3);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule